// File: doc/BRIEF.md
# Calendar Alarm Comparator and Interrupt Status Unit

This unit sits beside the calendar counter chain of a timekeeping block. It keeps six alarm reference bytes (seconds, minutes, hours, day of month, month, day of week), each with its own compare enable. On every hundredths tick it checks the live counter values against the enabled references. A reference whose enable is clear counts as always equal. When all enabled bytes agree, the unit raises an alarm status bit. The same unit gathers the rollover strobes of six counter stages into a periodic flag register. Enabled rollovers raise a periodic pending bit.

Pending alarm and periodic conditions drive an active-low interrupt pin. The alarm can instead be steered to a second, active-high interrupt line. A host reads and writes the unit through a small register port. Flags clear when their register is read or written. The two pending bits clear when the host writes 1 to them. Read data is combinational from the addressed register.

Register addresses (4-bit): 0 main status, 1 periodic flags, 2 periodic enables, 3 compare enables, 4 alarm control, 8 to 13 the reference bytes in the order seconds, minutes, hours, day of month, month, day of week. The live time bus `cur_time` carries the same six bytes, with byte i at bits [8i+7:8i].

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, every register reads 0x00, `irq_n` is 1 and `irq_aux` is 0.
- R2: A reference byte whose compare-enable bit (register 3, bit i for byte i) is 0 is treated as equal. When all six enables are 0, the alarm status bit is never set.
- R3: On a cycle with `tick_hund` high, if every enabled reference byte equals its live byte and the match was absent at the previous tick, main status bit 3 is set. This happens whatever the alarm interrupt enable holds. A match that persists over later ticks raises no further event.
- R4: Writing 1 to main status bit 3 clears it. Writing 0 there, or writing 1 only to bit 2, leaves it unchanged.
- R5: A high `roll_stb[i]` sets periodic flag bit i of register 1. Here i runs 0 to 5 for 1/100 s, 1/10 s, second, 10 s, minute and hour. Any read or write of register 1 clears all flags. A strobe in the same cycle as that access still leaves its flag set afterwards.
- R6: Main status bit 2 is set when a strobe arrives on any stage whose enable bit in register 2 is 1. It is cleared only by writing 1 to that bit. It stays set after all periodic enables are cleared.
- R7: `irq_n` is 0 exactly when bit 2 is pending, or bit 3 is pending with alarm interrupt enable (register 4 bit 0) set and aux routing (register 4 bit 1) clear. `irq_aux` is 1 exactly when bit 3 is pending with both register 4 bits set.
- R8: Main status bit 0 reads 1 exactly when `irq_n` is 0 or `irq_aux` is 1. Bits 1 and 4 to 7 read 0.
- R9: When a set event and a write-one clear of the same pending bit or flag fall in one cycle, the bit ends up set.
- R10: Live-time changes without `tick_hund` never change the alarm status bit.
- R11: Registers 2, 3, 4 and 8 to 13 read back what was last written, in their implemented bits. Other writes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_hund | input | 1 | Hundredths tick strobe; alarm evaluation point |
| roll_stb | input | 6 | Rollover strobes of the six counter stages |
| cur_time | input | 48 | Live counter bytes, byte i at [8i+7:8i] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_n | output | 1 | Active-low interrupt |
| irq_aux | output | 1 | Active-high second interrupt for a routed alarm |

## Verification
The assertions assume that `tick_hund`, `roll_stb` and the register strobes are one-cycle pulses sampled on the clock. They also assume that `cur_time` is stable on the tick cycle and that read and write never collide. The bench drives every input at the falling edge, holds the live time constant around each tick, and issues one register access per cycle. Alarm behaviour is swept over all 64 compare-enable masks against all 64 patterns of mismatching bytes. Periodic behaviour is swept over all enable and strobe combinations. In both sweeps the expected status comes from a mask expression in the bench.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned REG_ADDR_W   = 4;
  localparam int unsigned ADR_MAIN     = 0;
  localparam int unsigned ADR_PFLAG    = 1;
  localparam int unsigned ADR_PEN      = 2;
  localparam int unsigned ADR_CMPEN    = 3;
  localparam int unsigned ADR_ACTL     = 4;
  localparam int unsigned ADR_CMP_BASE = 8;
  localparam int unsigned MS_IRQ       = 0;
  localparam int unsigned MS_PER       = 2;
  localparam int unsigned MS_ALM       = 3;
  localparam int unsigned ACTL_IE      = 0;
  localparam int unsigned ACTL_AUX     = 1;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NUM_CMP = 6,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic [NUM_CMP*BYTE_W-1:0]   cur_i,
  input  logic [NUM_CMP*BYTE_W-1:0]   ref_i,
  input  logic [NUM_CMP-1:0]          en_i,
  output logic                        evt_o
);
  logic [NUM_CMP-1:0] byte_ok;
  logic               match_now;
  logic               match_q;
  logic               match_d;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_byte
    assign byte_ok[g] = !en_i[g] ||
                        (cur_i[g*BYTE_W +: BYTE_W] == ref_i[g*BYTE_W +: BYTE_W]);
  end

  assign match_now = (&byte_ok) && (|en_i);

  always_comb begin
    match_d = match_q;
    if (tick_i) match_d = match_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign evt_o = tick_i && match_now && !match_q;

  p_evt_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> tick_i);
  p_all_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !evt_o);
  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/rtc_periodic_flags.sv
module rtc_periodic_flags #(
  parameter int unsigned NUM_PER = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PER-1:0] roll_i,
  input  logic               acc_i,
  output logic [NUM_PER-1:0] flags_o
);
  logic [NUM_PER-1:0] flags_q;
  logic [NUM_PER-1:0] flags_d;

  always_comb begin
    flags_d = acc_i ? '0 : flags_q;
    flags_d = flags_d | roll_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_access_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && roll_i == '0) |=> (flags_o == '0));
  p_roll_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_i != '0) |=> ((flags_o & $past(roll_i)) == $past(roll_i)));
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl #(
  parameter int unsigned NUM_PER = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PER-1:0] roll_i,
  input  logic [NUM_PER-1:0] per_en_i,
  input  logic               alarm_evt_i,
  input  logic               alarm_ie_i,
  input  logic               aux_i,
  input  logic               clr_per_i,
  input  logic               clr_alm_i,
  output logic               per_pend_o,
  output logic               alm_pend_o,
  output logic               irq_n_o,
  output logic               irq2_o
);
  logic per_pend_q, per_pend_d;
  logic alm_pend_q, alm_pend_d;
  logic per_evt;
  logic alm_irq;

  assign per_evt = |(roll_i & per_en_i);

  always_comb begin
    per_pend_d = per_evt     | (per_pend_q & !clr_per_i);
    alm_pend_d = alarm_evt_i | (alm_pend_q & !clr_alm_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_pend_q <= 1'b0;
      alm_pend_q <= 1'b0;
    end else begin
      per_pend_q <= per_pend_d;
      alm_pend_q <= alm_pend_d;
    end
  end

  assign alm_irq    = alm_pend_q & alarm_ie_i;
  assign irq_n_o    = !((alm_irq & !aux_i) | per_pend_q);
  assign irq2_o     = alm_irq & aux_i;
  assign per_pend_o = per_pend_q;
  assign alm_pend_o = alm_pend_q;

  p_idle_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_pend_q && !per_pend_q) |-> (irq_n_o && !irq2_o));
  p_alarm_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_pend_q && !alarm_evt_i) |=> !alm_pend_q);
  p_per_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (per_pend_q && !clr_per_i) |=> per_pend_q);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt_i |=> alm_pend_q);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned NUM_CMP = 6,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NUM_PER = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_hund,
  input  logic [NUM_PER-1:0]        roll_stb,
  input  logic [NUM_CMP*BYTE_W-1:0] cur_time,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [REG_ADDR_W-1:0]     reg_addr,
  input  logic [BYTE_W-1:0]         reg_wdata,
  output logic [BYTE_W-1:0]         reg_rdata,
  output logic                      irq_n,
  output logic                      irq_aux
);
  localparam int unsigned CMP_W = NUM_CMP * BYTE_W;

  // reset: asynchronous assertion, two-stage synchronous release
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // address decode
  logic sel_main, sel_pflag, sel_pen, sel_cmpen, sel_actl;
  assign sel_main  = (reg_addr == REG_ADDR_W'(ADR_MAIN));
  assign sel_pflag = (reg_addr == REG_ADDR_W'(ADR_PFLAG));
  assign sel_pen   = (reg_addr == REG_ADDR_W'(ADR_PEN));
  assign sel_cmpen = (reg_addr == REG_ADDR_W'(ADR_CMPEN));
  assign sel_actl  = (reg_addr == REG_ADDR_W'(ADR_ACTL));

  // configuration registers
  logic [NUM_PER-1:0] per_en_q, per_en_d;
  logic [NUM_CMP-1:0] cmp_en_q, cmp_en_d;
  logic [1:0]         actl_q,   actl_d;
  logic [CMP_W-1:0]   cmp_q,    cmp_d;

  always_comb begin
    per_en_d = per_en_q;
    cmp_en_d = cmp_en_q;
    actl_d   = actl_q;
    cmp_d    = cmp_q;
    if (reg_wr && sel_pen)   per_en_d = reg_wdata[NUM_PER-1:0];
    if (reg_wr && sel_cmpen) cmp_en_d = reg_wdata[NUM_CMP-1:0];
    if (reg_wr && sel_actl)  actl_d   = {reg_wdata[ACTL_AUX], reg_wdata[ACTL_IE]};
    for (int i = 0; i < NUM_CMP; i++) begin
      if (reg_wr && reg_addr == REG_ADDR_W'(ADR_CMP_BASE + i))
        cmp_d[i*BYTE_W +: BYTE_W] = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      per_en_q <= '0;
      cmp_en_q <= '0;
      actl_q   <= '0;
      cmp_q    <= '0;
    end else begin
      per_en_q <= per_en_d;
      cmp_en_q <= cmp_en_d;
      actl_q   <= actl_d;
      cmp_q    <= cmp_d;
    end
  end

  // strobes toward the status logic
  logic clr_per, clr_alm, flag_acc;
  assign clr_per  = reg_wr && sel_main && reg_wdata[MS_PER];
  assign clr_alm  = reg_wr && sel_main && reg_wdata[MS_ALM];
  assign flag_acc = (reg_wr || reg_rd) && sel_pflag;

  logic               alarm_evt;
  logic [NUM_PER-1:0] flags;
  logic               per_pend, alm_pend;

  rtc_alarm_cmp #(.NUM_CMP(NUM_CMP), .BYTE_W(BYTE_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick_i (tick_hund),
    .cur_i  (cur_time),
    .ref_i  (cmp_q),
    .en_i   (cmp_en_q),
    .evt_o  (alarm_evt)
  );

  rtc_periodic_flags #(.NUM_PER(NUM_PER)) u_flags (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .roll_i  (roll_stb),
    .acc_i   (flag_acc),
    .flags_o (flags)
  );

  rtc_irq_ctl #(.NUM_PER(NUM_PER)) u_irq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .roll_i      (roll_stb),
    .per_en_i    (per_en_q),
    .alarm_evt_i (alarm_evt),
    .alarm_ie_i  (actl_q[0]),
    .aux_i       (actl_q[1]),
    .clr_per_i   (clr_per),
    .clr_alm_i   (clr_alm),
    .per_pend_o  (per_pend),
    .alm_pend_o  (alm_pend),
    .irq_n_o     (irq_n),
    .irq2_o      (irq_aux)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (sel_main) begin
      reg_rdata[MS_IRQ] = !irq_n || irq_aux;
      reg_rdata[MS_PER] = per_pend;
      reg_rdata[MS_ALM] = alm_pend;
    end
    if (sel_pflag) reg_rdata[NUM_PER-1:0] = flags;
    if (sel_pen)   reg_rdata[NUM_PER-1:0] = per_en_q;
    if (sel_cmpen) reg_rdata[NUM_CMP-1:0] = cmp_en_q;
    if (sel_actl)  reg_rdata[1:0]         = actl_q;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (reg_addr == REG_ADDR_W'(ADR_CMP_BASE + i))
        reg_rdata = cmp_q[i*BYTE_W +: BYTE_W];
    end
  end

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !reg_wr |=> $stable(cmp_q));
endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_hund = 1'b0;
  logic [5:0]  roll_stb = '0;
  logic [47:0] cur_time = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_n, irq_aux;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_irq dut (
    .clk(clk), .rst_n(rst_n), .tick_hund(tick_hund), .roll_stb(roll_stb),
    .cur_time(cur_time), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n), .irq_aux(irq_aux)
  );

  function automatic logic [7:0] ref_byte(int i);
    return 8'h21 + 8'(8'h11 * i);
  endfunction

  function automatic logic [47:0] mk_time(logic [5:0] miss);
    logic [47:0] t;
    for (int i = 0; i < 6; i++) t[i*8 +: 8] = ref_byte(i) ^ {7'd0, miss[i]};
    return t;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic do_tick(logic [47:0] t);
    @(negedge clk); cur_time = t; tick_hund = 1'b1;
    @(negedge clk); tick_hund = 1'b0;
  endtask

  task automatic do_roll(logic [5:0] p);
    @(negedge clk); roll_stb = p;
    @(negedge clk); roll_stb = '0;
  endtask

  task automatic pins(string tag, logic en, logic ea);
    #1;
    chk(tag, {6'd0, irq_n, irq_aux}, {6'd0, en, ea});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      do_rd(4'(a), d); chk("R1 reset register", d, 8'h00);
    end
    pins("R1 reset pins", 1'b1, 1'b0);

    // R11 readback
    for (int i = 0; i < 6; i++) do_wr(4'(8 + i), ref_byte(i));
    for (int i = 0; i < 6; i++) begin
      do_rd(4'(8 + i), d); chk("R11 reference byte", d, ref_byte(i));
    end
    do_wr(4'd2, 8'hFF); do_rd(4'd2, d); chk("R11 periodic enables", d, 8'h3F);
    do_wr(4'd2, 8'h00);
    do_wr(4'd4, 8'hFE); do_rd(4'd4, d); chk("R11 alarm control", d, 8'h02);
    do_wr(4'd4, 8'h00);

    // R2 R3 sweep: enables x mismatch patterns, interrupt masked
    for (int e = 0; e < 64; e++) begin
      do_wr(4'd3, 8'(e));
      for (int m = 0; m < 64; m++) begin
        do_tick(mk_time(6'h3F));
        do_wr(4'd0, 8'h0C);
        do_tick(mk_time(6'(m)));
        do_rd(4'd0, d);
        chk("R2/R3 alarm sweep", d,
            ((e != 0) && ((e & m) == 0)) ? 8'h08 : 8'h00);
        #1 if (irq_n !== 1'b1) chk("R3 masked pin", {7'd0, irq_n}, 8'h01);
      end
    end

    // R3 R7 R8 enabled alarm, single event
    do_wr(4'd3, 8'h3F);
    do_wr(4'd4, 8'h01);
    do_tick(mk_time(6'h3F));
    do_wr(4'd0, 8'h0C);
    do_tick(mk_time(6'h00));
    do_rd(4'd0, d); chk("R3/R8 alarm status", d, 8'h09);
    pins("R7 alarm on irq_n", 1'b0, 1'b1 & 1'b0);
    do_wr(4'd0, 8'h08);
    do_tick(mk_time(6'h00));
    do_rd(4'd0, d); chk("R3 persistent match no event", d, 8'h00);
    pins("R7 idle pins", 1'b1, 1'b0);

    // R10 time change without tick
    do_tick(mk_time(6'h01));
    @(negedge clk); cur_time = mk_time(6'h00);
    repeat (3) @(negedge clk);
    do_rd(4'd0, d); chk("R10 no tick no event", d, 8'h00);
    do_tick(mk_time(6'h00));
    do_rd(4'd0, d); chk("R10 tick evaluates", d, 8'h09);

    // R4 clear rules
    do_wr(4'd0, 8'h00); do_rd(4'd0, d); chk("R4 write 0 keeps", d, 8'h09);
    do_wr(4'd0, 8'h04); do_rd(4'd0, d); chk("R4 other bit keeps", d, 8'h09);

    // R7 R8 aux routing
    do_wr(4'd4, 8'h03);
    pins("R7 alarm on aux", 1'b1, 1'b1);
    do_rd(4'd0, d); chk("R8 aux reflected", d, 8'h09);
    do_wr(4'd4, 8'h02);
    pins("R7 aux needs enable", 1'b1, 1'b0);
    do_rd(4'd0, d); chk("R8 masked alarm", d, 8'h08);
    do_wr(4'd0, 8'h08); do_rd(4'd0, d); chk("R4 write 1 clears", d, 8'h00);
    do_wr(4'd4, 8'h00);

    // R9 alarm set wins over clear
    do_tick(mk_time(6'h3F));
    @(negedge clk);
    cur_time = mk_time(6'h00); tick_hund = 1'b1;
    reg_addr = 4'd0; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(negedge clk); tick_hund = 1'b0; reg_wr = 1'b0;
    do_rd(4'd0, d); chk("R9 alarm set wins", d, 8'h08);
    do_wr(4'd0, 8'h08);
    do_wr(4'd3, 8'h00);

    // R5 flag sweep
    for (int p = 1; p < 64; p++) begin
      do_roll(6'(p));
      do_rd(4'd1, d); chk("R5 flags set", d, 8'(p));
      do_rd(4'd1, d); chk("R5 read clears", d, 8'h00);
    end
    do_roll(6'h3F);
    do_wr(4'd1, 8'h00);
    do_rd(4'd1, d); chk("R5 write clears", d, 8'h00);
    @(negedge clk); reg_addr = 4'd1; reg_rd = 1'b1; roll_stb = 6'h05;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; roll_stb = '0;
    chk("R5 read during strobe", d, 8'h00);
    do_rd(4'd1, d); chk("R9 flag set wins", d, 8'h05);

    // R6 pending sweep
    for (int e = 0; e < 64; e++) begin
      do_wr(4'd2, 8'(e));
      for (int p = 0; p < 64; p++) begin
        do_roll(6'(p));
        do_rd(4'd0, d);
        chk("R6/R8 periodic sweep", d, ((e & p) != 0) ? 8'h05 : 8'h00);
        #1 if (irq_n !== ((e & p) == 0))
          chk("R7 periodic pin", {7'd0, irq_n}, {7'd0, 1'((e & p) == 0)});
        do_wr(4'd0, 8'h04);
      end
    end
    do_wr(4'd2, 8'h01);
    do_roll(6'h01);
    do_wr(4'd2, 8'h00);
    do_rd(4'd0, d); chk("R6 pending after disable", d, 8'h05);
    pins("R7 periodic pin low", 1'b0, 1'b0);
    do_wr(4'd0, 8'h08); do_rd(4'd0, d); chk("R6 alarm clear ignored", d, 8'h05);
    do_wr(4'd0, 8'h04); do_rd(4'd0, d); chk("R6 write 1 clears", d, 8'h00);
    do_wr(4'd2, 8'h02);
    @(negedge clk); roll_stb = 6'h02;
    reg_addr = 4'd0; reg_wdata = 8'h04; reg_wr = 1'b1;
    @(negedge clk); roll_stb = '0; reg_wr = 1'b0;
    do_rd(4'd0, d); chk("R9 periodic set wins", d, 8'h05);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule